// File: doc/BRIEF.md
# Keyed-service watchdog timer

This block is a watchdog timer run by software through three 16-bit halfword registers on a simple synchronous bus. Software sets a timeout in half-second steps and a few control flags in the control register. It keeps the timer from expiring by writing a two-word key into the service register. A shared prescaler divides the system clock into a half-second tick, and the countdown advances once per tick.

When the countdown runs out, the block drives a reset request pulse of fixed length, or a separate timeout pulse if software routed the event there. A status register records whether the most recent reset came from power-on or from the watchdog. Two reset inputs keep the record: `por_n` clears everything, while `rst_n` (the system reset that the reset request normally drives) clears the control and count state but leaves the status register alone.

Top module: `wdog_keyed`

## Requirements
- R1: Byte address 0x0 selects control (read/write), 0x2 selects service (write only, reads 0x0000), 0x4 selects status (read only, writes have no effect). Any other address reads 0x0000.
- R2: The countdown reloads only on a service write of 0xAAAA whose previous service write was 0x5555. A service write of any other value re-arms the sequencer to wait for 0x5555. Another 0x5555 keeps it armed. Writes to other addresses leave the sequencer unchanged.
- R3: The timeout field is control[15:8]. After the reloading 0xAAAA write, reset_req rises exactly (field+1)×TICK_CYC clock cycles later if counting is never suspended.
- R4: Control bit 2 is enable, bit 3 routes the timeout, bit 0 is the low-power suspend, bit 1 is the debug suspend, and bit 7 is a free flag. All 16 control bits are stored and read back as written, except that enable is sticky.
- R5: While control[0]=1 and lowpwr_i=1, both the countdown and the prescaler hold. With control[0]=0, lowpwr_i has no effect.
- R6: While control[1]=1 and debug_i=1, both the countdown and the prescaler hold. With control[1]=0, debug_i has no effect.
- R7: Once set, control[2] ignores writes of 0 until rst_n or por_n.
- R8: On expiry with control[3]=0, reset_req goes high for exactly RST_CYC cycles. With control[3]=1, tmo_o pulses for RST_CYC cycles instead and reset_req stays low.
- R9: After por_n the status register reads 0x0010. A reset_req pulse makes it read 0x0002. It keeps its value through rst_n, and only por_n clears it.
- R10: A write to the timeout field during a countdown does not change that countdown. The new value is used from the next reload.
- R11: Writing control=0x0004 and then a valid service sequence gives a reset_req pulse TICK_CYC cycles (one half-second tick) after the 0xAAAA write.
- R12: Nothing counts while enable is 0. After either reset the countdown holds one tick, so setting enable without servicing leads to expiry TICK_CYC cycles after the enabling write. After an expiry the countdown stays idle until the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| rst_n | input | 1 | System reset, active low, keeps the status register |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| lowpwr_i | input | 1 | Low-power state indication |
| debug_i | input | 1 | Debug halt indication |
| reset_req | output | 1 | Reset request pulse on timeout |
| tmo_o | output | 1 | Timeout pulse when routed away from reset |

## Verification
Two events can land in the same cycle. A reload can coincide with a prescaler tick, and a suspend can coincide with the tick that would have expired the count. The bench stretches the countdown by holding a suspend input for a chosen number of cycles that begins right after the reload edge. It then requires the expiry cycle to move by exactly that many cycles, and by none when the matching control bit is clear. It also rewrites the timeout field one cycle after a reload and checks that the expiry cycle still follows the value in force at the reload.

// File: rtl/wdk_pkg.sv
`timescale 1ns/1ps
package wdk_pkg;
   localparam int          HW_W     = 16;
   localparam int          FIELD_W  = 8;
   localparam int          CNT_W    = FIELD_W + 1;
   localparam int          OFS_CTL  = 0;
   localparam int          OFS_SVC  = 2;
   localparam int          OFS_STS  = 4;
   localparam logic [15:0] KEY_ARM  = 16'h5555;
   localparam logic [15:0] KEY_FIRE = 16'hAAAA;
   localparam int          B_LP     = 0;
   localparam int          B_DBG    = 1;
   localparam int          B_EN     = 2;
   localparam int          B_ROUTE  = 3;
   localparam logic [15:0] CTL_RST  = 16'h0000;
   localparam int          ST_WD    = 1;
   localparam int          ST_POR   = 4;
   typedef enum logic {SEQ_IDLE = 1'b0, SEQ_ARMED = 1'b1} seq_e;
endpackage

// File: rtl/wdk_prescale.sv
`timescale 1ns/1ps
module wdk_prescale #(
   parameter int TICK_CYC = 4
) (
   input  logic clk,
   input  logic arst_n,
   input  logic run_i,
   input  logic clr_i,
   output logic tick_o
);
   localparam int PW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;

   if (TICK_CYC < 1) begin : g_bad
      $error("wdk_prescale: TICK_CYC must be at least 1");
   end

   if (TICK_CYC == 1) begin : g_direct
      assign tick_o = run_i && !clr_i;
   end else begin : g_count
      logic [PW-1:0] pre_q;
      logic          wrap;
      assign wrap   = (pre_q == PW'(TICK_CYC - 1));
      assign tick_o = run_i && !clr_i && wrap;

      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n)       pre_q <= '0;
         else if (clr_i)    pre_q <= '0;
         else if (run_i) begin
            if (wrap)       pre_q <= '0;
            else            pre_q <= pre_q + 1'b1;
         end
      end

      AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!arst_n)
         pre_q <= PW'(TICK_CYC - 1));                                   // R3
      AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!arst_n)
         (!run_i && !clr_i) |=> $stable(pre_q));                        // R5
   end
endmodule

// File: rtl/wdk_keyseq.sv
`timescale 1ns/1ps
module wdk_keyseq import wdk_pkg::*; (
   input  logic            clk,
   input  logic            arst_n,
   input  logic            wr_i,
   input  logic [HW_W-1:0] data_i,
   output logic            reload_o
);
   seq_e st_q;

   assign reload_o = wr_i && (st_q == SEQ_ARMED) && (data_i == KEY_FIRE);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)                      st_q <= SEQ_IDLE;
      else if (wr_i) begin
         if (data_i == KEY_ARM)         st_q <= SEQ_ARMED;
         else                           st_q <= SEQ_IDLE;
      end
   end

   AST_ARM_BY_KEY: assert property (@(posedge clk) disable iff (!arst_n)
      (st_q == SEQ_ARMED && $past(st_q) == SEQ_IDLE) |-> $past(wr_i && data_i == KEY_ARM)); // R2
   AST_FIRE_DISARMS: assert property (@(posedge clk) disable iff (!arst_n)
      reload_o |=> (st_q == SEQ_IDLE));                                 // R2
endmodule

// File: rtl/wdk_count.sv
`timescale 1ns/1ps
module wdk_count #(
   parameter int CNT_W   = 9,
   parameter int RST_VAL = 1
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic             reload_i,
   input  logic [CNT_W-1:0] load_i,
   input  logic             tick_i,
   output logic             running_o,
   output logic             expire_o
);
   logic [CNT_W-1:0] cnt_q;

   if (RST_VAL < 0 || RST_VAL >= (1 << CNT_W)) begin : g_bad
      $error("wdk_count: RST_VAL out of range");
   end

   assign running_o = (cnt_q != '0);
   assign expire_o  = tick_i && !reload_i && (cnt_q == CNT_W'(1));

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)                   cnt_q <= CNT_W'(RST_VAL);
      else if (reload_i)             cnt_q <= load_i;
      else if (tick_i && running_o)  cnt_q <= cnt_q - 1'b1;
   end

   AST_RELOAD_ONLY_KEY: assert property (@(posedge clk) disable iff (!arst_n)
      (cnt_q > $past(cnt_q)) |-> $past(reload_i));                      // R2
   AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!arst_n)
      (!tick_i && !reload_i) |=> $stable(cnt_q));                       // R12
   AST_EXPIRE_ZERO: assert property (@(posedge clk) disable iff (!arst_n)
      expire_o |=> !running_o);                                         // R3
endmodule

// File: rtl/wdk_pulse.sv
`timescale 1ns/1ps
module wdk_pulse #(
   parameter int LEN = 16
) (
   input  logic clk,
   input  logic arst_n,
   input  logic start_i,
   output logic pulse_o
);
   localparam int PC_W = $clog2(LEN + 1);
   localparam int HR_W = $clog2(LEN + 2);

   if (LEN < 1) begin : g_bad
      $error("wdk_pulse: LEN must be at least 1");
   end

   logic [PC_W-1:0] pc_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         pulse_o <= 1'b0;
         pc_q    <= '0;
      end else if (start_i && !pulse_o) begin
         pulse_o <= 1'b1;
         pc_q    <= PC_W'(LEN - 1);
      end else if (pulse_o) begin
         if (pc_q == '0) pulse_o <= 1'b0;
         else            pc_q    <= pc_q - 1'b1;
      end
   end

   // checker: length of the current high run
   logic [HR_W-1:0] hi_run;
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)                             hi_run <= '0;
      else if (!pulse_o)                       hi_run <= '0;
      else if (hi_run != HR_W'(LEN + 1))       hi_run <= hi_run + 1'b1;
   end

   AST_PULSE_MAX: assert property (@(posedge clk) disable iff (!arst_n)
      hi_run <= HR_W'(LEN));                                            // R8
   AST_PULSE_FULL: assert property (@(posedge clk) disable iff (!arst_n)
      $fell(pulse_o) |-> ($past(hi_run) == HR_W'(LEN - 1)));            // R8
endmodule

// File: rtl/wdog_keyed.sv
`timescale 1ns/1ps
module wdog_keyed import wdk_pkg::*; #(
   parameter int TICK_CYC = 50_000_000,
   parameter int RST_CYC  = 16,
   parameter int ADDR_W   = 3
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [HW_W-1:0]   bus_wdata,
   output logic [HW_W-1:0]   bus_rdata,
   input  logic              lowpwr_i,
   input  logic              debug_i,
   output logic              reset_req,
   output logic              tmo_o
);
   if (ADDR_W < 3) begin : g_bad_addr
      $error("wdog_keyed: ADDR_W must reach offset 0x4");
   end

   logic            arst_n;
   logic            sel_ctl, sel_svc, sel_sts;
   logic [HW_W-1:0] ctl_q;
   logic            st_por_q, st_wd_q;
   logic            reload, tick, running, expire, adv, susp;
   logic            start_rst, start_tmo;

   assign arst_n  = por_n & rst_n;
   assign sel_ctl = (bus_addr == ADDR_W'(OFS_CTL));
   assign sel_svc = (bus_addr == ADDR_W'(OFS_SVC));
   assign sel_sts = (bus_addr == ADDR_W'(OFS_STS));

   // control register, enable bit sticky
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)                 ctl_q <= CTL_RST;
      else if (bus_we && sel_ctl) begin
         ctl_q        <= bus_wdata;
         ctl_q[B_EN]  <= bus_wdata[B_EN] | ctl_q[B_EN];
      end
   end

   // status register, power-on domain only
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         st_por_q <= 1'b1;
         st_wd_q  <= 1'b0;
      end else if (start_rst) begin
         st_por_q <= 1'b0;
         st_wd_q  <= 1'b1;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (sel_ctl) bus_rdata = ctl_q;
      else if (sel_sts) begin
         bus_rdata[ST_POR] = st_por_q;
         bus_rdata[ST_WD]  = st_wd_q;
      end
   end

   assign susp = (ctl_q[B_LP] && lowpwr_i) || (ctl_q[B_DBG] && debug_i);
   assign adv  = ctl_q[B_EN] && !susp && running;

   wdk_keyseq u_keyseq (
      .clk      (clk),
      .arst_n   (arst_n),
      .wr_i     (bus_we && sel_svc),
      .data_i   (bus_wdata),
      .reload_o (reload)
   );

   wdk_prescale #(.TICK_CYC(TICK_CYC)) u_prescale (
      .clk    (clk),
      .arst_n (arst_n),
      .run_i  (adv),
      .clr_i  (reload),
      .tick_o (tick)
   );

   wdk_count #(.CNT_W(CNT_W), .RST_VAL(int'(CTL_RST[15:8]) + 1)) u_count (
      .clk       (clk),
      .arst_n    (arst_n),
      .reload_i  (reload),
      .load_i    ({1'b0, ctl_q[15:8]} + 1'b1),
      .tick_i    (tick),
      .running_o (running),
      .expire_o  (expire)
   );

   assign start_rst = expire && !ctl_q[B_ROUTE];
   assign start_tmo = expire &&  ctl_q[B_ROUTE];

   wdk_pulse #(.LEN(RST_CYC)) u_pulse_rst (
      .clk     (clk),
      .arst_n  (arst_n),
      .start_i (start_rst),
      .pulse_o (reset_req)
   );

   wdk_pulse #(.LEN(RST_CYC)) u_pulse_tmo (
      .clk     (clk),
      .arst_n  (arst_n),
      .start_i (start_tmo),
      .pulse_o (tmo_o)
   );

   AST_EN_STICKY: assert property (@(posedge clk) disable iff (!arst_n)
      $past(ctl_q[B_EN]) |-> ctl_q[B_EN]);                              // R7
   AST_LP_FREEZE: assert property (@(posedge clk) disable iff (!arst_n)
      (ctl_q[B_LP] && lowpwr_i) |-> !tick);                             // R5
   AST_DBG_FREEZE: assert property (@(posedge clk) disable iff (!arst_n)
      (ctl_q[B_DBG] && debug_i) |-> !tick);                             // R6
   AST_OFF_NO_TICK: assert property (@(posedge clk) disable iff (!arst_n)
      !ctl_q[B_EN] |-> !tick);                                          // R12
   AST_STATUS_ONE: assert property (@(posedge clk) disable iff (!por_n)
      $onehot({st_por_q, st_wd_q}));                                    // R9
   AST_STATUS_MARK: assert property (@(posedge clk) disable iff (!arst_n)
      $rose(reset_req) |-> st_wd_q);                                    // R9
endmodule

// File: tb/tb_wdog_keyed.sv
`timescale 1ns/1ps
module tb_wdog_keyed;
   localparam int CLK_PER = 10;
   localparam int T       = 4;
   localparam int RC      = 3;

   logic        clk = 1'b0;
   logic        por_n = 1'b0, rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        lowpwr_i = 1'b0, debug_i = 1'b0;
   logic        reset_req, tmo_o;

   int checks = 0, errors = 0;

   always #(CLK_PER/2) clk = ~clk;

   wdog_keyed #(.TICK_CYC(T), .RST_CYC(RC), .ADDR_W(3)) dut (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_addr(bus_addr),
      .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .lowpwr_i(lowpwr_i), .debug_i(debug_i), .reset_req(reset_req), .tmo_o(tmo_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk); #1;
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output int v);
      @(negedge clk);
      bus_addr = a; #1;
      v = int'(bus_rdata);
   endtask

   task automatic svc();
      wr(3'd2, 16'h5555);
      wr(3'd2, 16'hAAAA);
   endtask

   // called right after the reloading edge; k counts negedges after it
   task automatic run(input int start_k, input int susp, input int s_len,
                      input bit use_tmo, output int k, output int width,
                      output bit other);
      k = start_k; width = 0; other = 1'b0;
      if (susp == 1) lowpwr_i = 1'b1;
      if (susp == 2) debug_i  = 1'b1;
      while (1) begin
         @(negedge clk);
         k++;
         if (k == s_len) begin lowpwr_i = 1'b0; debug_i = 1'b0; end
         if (use_tmo ? reset_req : tmo_o) other = 1'b1;
         if (use_tmo ? tmo_o : reset_req) break;
         if (k > 3000) break;
      end
      lowpwr_i = 1'b0; debug_i = 1'b0;
      while ((use_tmo ? tmo_o : reset_req) && width < 100) begin
         width++;
         @(negedge clk);
         if (use_tmo ? reset_req : tmo_o) other = 1'b1;
      end
   endtask

   task automatic quiet(input int n, output bit seen);
      seen = 1'b0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (reset_req || tmo_o) seen = 1'b1;
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(CLK_PER * 150000);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      int v, k, w;
      bit o, seen;
      repeat (3) @(negedge clk);
      por_n = 1'b1; rst_n = 1'b1;

      // reset state
      rd(3'd4, v); chk("R9 status after power-on", v, 16'h0010);
      rd(3'd0, v); chk("R1 control after reset", v, 0);
      rd(3'd2, v); chk("R1 service reads zero", v, 0);
      rd(3'd6, v); chk("R1 unmapped reads zero", v, 0);
      chk("R8 reset_req idle", int'(reset_req), 0);

      // disabled: no counting
      svc();
      quiet(3*T, seen); chk("R12 no expiry while disabled", int'(seen), 0);

      // control readback
      wr(3'd0, 16'hA5F3);
      rd(3'd0, v); chk("R4 control readback", v, 16'hA5F3);
      wr(3'd0, 16'h0000);

      // status write ignored
      wr(3'd4, 16'hFFFF);
      rd(3'd4, v); chk("R1 status write ignored", v, 16'h0010);

      // enable without service: one tick
      wr(3'd0, 16'h0004);
      run(0, 0, 0, 1'b0, k, w, o);
      chk("R12 expiry from enable alone", k, T + 1);
      chk("R8 pulse width", w, RC);
      rd(3'd4, v); chk("R9 status after watchdog", v, 16'h0002);

      // sticky enable
      wr(3'd0, 16'h0000);
      rd(3'd0, v); chk("R7 enable sticky", v, 16'h0004);

      // sweep of timeout field
      for (int i = 0; i < 9; i++) begin
         int f;
         f = (i == 8) ? 255 : i;
         wr(3'd0, 16'((f << 8) | 4));
         svc();
         run(0, 0, 0, 1'b0, k, w, o);
         chk($sformatf("R3 expiry field %0d", f), k, (f + 1) * T + 1);
         chk($sformatf("R8 width field %0d", f), w, RC);
      end

      // field change mid countdown
      wr(3'd0, 16'h0204);
      svc();
      wr(3'd0, 16'h0704);
      run(1, 0, 0, 1'b0, k, w, o);
      chk("R10 mid-count field write ignored", k, 3*T + 1);
      svc();
      run(0, 0, 0, 1'b0, k, w, o);
      chk("R10 new field at next reload", k, 8*T + 1);

      // low-power suspend
      wr(3'd0, 16'h0105); svc();
      run(0, 1, 10, 1'b0, k, w, o);
      chk("R5 low-power stretches count", k, 2*T + 10);
      wr(3'd0, 16'h0104); svc();
      run(0, 1, 10, 1'b0, k, w, o);
      chk("R5 low-power ignored when bit0 clear", k, 2*T + 1);

      // debug suspend
      wr(3'd0, 16'h0106); svc();
      run(0, 2, 7, 1'b0, k, w, o);
      chk("R6 debug stretches count", k, 2*T + 7);
      wr(3'd0, 16'h0104); svc();
      run(0, 2, 7, 1'b0, k, w, o);
      chk("R6 debug ignored when bit1 clear", k, 2*T + 1);

      // key sequence on idle counter (field 1 loaded)
      wr(3'd2, 16'hAAAA);
      quiet(3*T + 4, seen); chk("R2 lone 0xAAAA no reload", int'(seen), 0);
      wr(3'd2, 16'h5555); wr(3'd2, 16'h1234); wr(3'd2, 16'hAAAA);
      quiet(3*T + 4, seen); chk("R2 broken sequence no reload", int'(seen), 0);
      wr(3'd2, 16'h5555); wr(3'd2, 16'h5555); wr(3'd2, 16'hAAAA);
      run(0, 0, 0, 1'b0, k, w, o);
      chk("R2 repeated 0x5555 then 0xAAAA reloads", k, 2*T + 1);
      wr(3'd2, 16'h5555); wr(3'd0, 16'h0104); wr(3'd2, 16'hAAAA);
      run(0, 0, 0, 1'b0, k, w, o);
      chk("R2 other address keeps sequencer armed", k, 2*T + 1);

      // system reset keeps status
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      rd(3'd4, v); chk("R9 status kept across system reset", v, 16'h0002);
      rd(3'd0, v); chk("R7 enable cleared by system reset", v, 0);

      // routing to tmo_o
      wr(3'd0, 16'h000C); svc();
      run(0, 0, 0, 1'b1, k, w, o);
      chk("R8 routed pulse timing", k, T + 1);
      chk("R8 routed pulse width", w, RC);
      chk("R8 reset_req silent when routed", int'(o), 0);
      rd(3'd4, v); chk("R9 status unchanged by routed timeout", v, 16'h0002);

      // minimum timeout
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      wr(3'd0, 16'h0004); svc();
      run(0, 0, 0, 1'b0, k, w, o);
      chk("R11 minimum half-second timeout", k, T + 1);
      chk("R11 tmo_o silent", int'(o), 0);

      // power-on clears status
      @(negedge clk); por_n = 1'b0;
      @(negedge clk); por_n = 1'b1;
      rd(3'd4, v); chk("R9 status cleared by power-on", v, 16'h0010);

      finish_run();
   end
endmodule